// File: doc/BRIEF.md
# Machine Trap State Registers

This block keeps the machine-level trap state of a small RISC-V-style core: the global interrupt enable, the current privilege mode, their saved copies, the handler base address, the saved return PC, the cause word and the trap value word. The control unit pulses a one-cycle entry strobe when it decides to take a trap. In that single clock edge every status, cause, PC and value update happens together, so the handler never sees a half-updated state. A one-cycle leave strobe restores the enable and privilege that were in force before the trap.

The PC, cause and value words are sampled on the same edge as the entry strobe. The caller therefore supplies the PC that was captured when the trap was raised, not the PC that is currently live. The handler base address is always present on an output, so the fetch logic can redirect to it in the cycle after entry. A plain CSR port lets software read all of these registers and write the writable ones. Any write aimed at the read-only address range is refused and flagged at once as an access fault.

Top module: `trap_csr_unit`

## Requirements
- R1: On an edge with `trap_enter` high, the saved-enable bit takes the value `irq_enable` had before that edge, and `irq_enable` becomes 0.
- R2: On an edge with `trap_enter` high, the saved-privilege field takes the value `priv_mode` had before that edge, and `priv_mode` becomes 2'b11.
- R3: On an edge with `trap_enter` high, `resume_pc` takes `trap_pc`, the cause register takes `trap_cause`, and the value register takes `trap_value`, all as sampled on that edge.
- R4: `handler_base` always shows the vector register at address 0x305. After reset it holds `VEC_RESET`, and a plain CSR write can change it.
- R5: On an edge with `trap_leave` high and `trap_enter` low, `irq_enable` takes the saved-enable bit and `priv_mode` takes the saved-privilege field. The saved-enable bit is then set to 1 and the saved-privilege field is set to 2'b00.
- R6: When both strobes are high on the same edge, only the entry updates take place.
- R7: The address map is as follows: status 0x300, vector 0x305, return PC 0x341, cause 0x342, value 0x343. In the status word, bit 3 is the enable, bit 7 is the saved enable, bits 12:11 are the saved privilege, and all other bits read 0. Only those status fields can be written. A write made with neither strobe high updates the addressed register on the clock edge. `csr_rdata` shows the register selected by `csr_addr` with no clock delay.
- R8: A write whose address has bits [11:10] equal to 2'b11 drives `csr_fault` high in the same cycle and changes no state. A write to any other address keeps `csr_fault` low.
- R9: A CSR write made in the same cycle as either strobe changes no register.
- R10: After reset, `irq_enable` is 0, `priv_mode` is 2'b11, the saved fields are 0, and the return PC, cause and value registers are 0.
- R11: A writable-range address that is not in the map reads 0, and a write to it has no effect and raises no fault.
- R12: Address 0xF14 reads the `HART_ID` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_enter | input | 1 | One-cycle trap entry strobe |
| trap_leave | input | 1 | One-cycle trap return strobe |
| trap_cause | input | XLEN | Cause word to record on entry |
| trap_pc | input | XLEN | PC captured when the trap was raised |
| trap_value | input | XLEN | Exception-specific value, such as a faulting address |
| csr_wr | input | 1 | CSR write request |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data |
| csr_fault | output | 1 | Access fault on a write to the read-only range |
| handler_base | output | XLEN | Trap handler address |
| resume_pc | output | XLEN | Saved PC used for return |
| irq_enable | output | 1 | Global interrupt enable |
| priv_mode | output | 2 | Current privilege mode |

## Verification
A wrong saved-enable or saved-privilege field stays hidden until the next leave strobe. It then appears on `irq_enable` and `priv_mode` one edge later, so the bench reads back the status word and also forces a leave before the next entry. A cause, PC or value register that is loaded from the wrong source, or a cycle late, shows up on `csr_rdata` or `resume_pc` right after the entry edge. A write that wrongly gets through during a strobe, or to the read-only range, changes a readback value on the very next cycle.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

    localparam int CSR_AW = 12;

    typedef logic [1:0] priv_t;
    localparam priv_t PRIV_USER = 2'b00;
    localparam priv_t PRIV_MACH = 2'b11;

    localparam logic [CSR_AW-1:0] ADR_STATUS = 12'h300;
    localparam logic [CSR_AW-1:0] ADR_VECTOR = 12'h305;
    localparam logic [CSR_AW-1:0] ADR_RETPC  = 12'h341;
    localparam logic [CSR_AW-1:0] ADR_CAUSE  = 12'h342;
    localparam logic [CSR_AW-1:0] ADR_VALUE  = 12'h343;
    localparam logic [CSR_AW-1:0] ADR_HARTID = 12'hF14;

    localparam int BIT_IE    = 3;
    localparam int BIT_PIE   = 7;
    localparam int BIT_PPRIV = 11;

    typedef struct packed {
        logic  ie;
        logic  pie;
        priv_t priv;
        priv_t ppriv;
    } status_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_VECTOR,
        SEL_RETPC,
        SEL_CAUSE,
        SEL_VALUE,
        SEL_HARTID
    } csr_sel_e;

endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec
    import trap_csr_pkg::*;
(
    input  logic [CSR_AW-1:0] addr,
    output csr_sel_e          sel,
    output logic              read_only
);
    always_comb begin
        read_only = (addr[CSR_AW-1:CSR_AW-2] == 2'b11);
        unique case (addr)
            ADR_STATUS: sel = SEL_STATUS;
            ADR_VECTOR: sel = SEL_VECTOR;
            ADR_RETPC:  sel = SEL_RETPC;
            ADR_CAUSE:  sel = SEL_CAUSE;
            ADR_VALUE:  sel = SEL_VALUE;
            ADR_HARTID: sel = SEL_HARTID;
            default:    sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/trap_status_reg.sv
module trap_status_reg
    import trap_csr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enter,
    input  logic    leave,
    input  logic    wr_en,
    input  logic    wr_ie,
    input  logic    wr_pie,
    input  priv_t   wr_ppriv,
    output status_t st_q
);
    status_t st_d;

    always_comb begin
        st_d = st_q;
        if (enter) begin
            st_d.pie   = st_q.ie;
            st_d.ie    = 1'b0;
            st_d.ppriv = st_q.priv;
            st_d.priv  = PRIV_MACH;
        end else if (leave) begin
            st_d.ie    = st_q.pie;
            st_d.priv  = st_q.ppriv;
            st_d.pie   = 1'b1;
            st_d.ppriv = PRIV_USER;
        end else if (wr_en) begin
            st_d.ie    = wr_ie;
            st_d.pie   = wr_pie;
            st_d.ppriv = wr_ppriv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ie: 1'b0, pie: 1'b0, priv: PRIV_MACH, ppriv: PRIV_USER};
        end else begin
            st_q <= st_d;
        end
    end

    AST_ENTER_SAVES_IE: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (!st_q.ie && st_q.pie == $past(st_q.ie)));                 // R1
    AST_ENTER_SAVES_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (st_q.priv == PRIV_MACH && st_q.ppriv == $past(st_q.priv))); // R2
    AST_LEAVE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (leave && !enter) |=> (st_q.ie == $past(st_q.pie) &&
                               st_q.priv == $past(st_q.ppriv) &&
                               st_q.pie && st_q.ppriv == PRIV_USER));        // R5
endmodule

// File: rtl/trap_data_regs.sv
module trap_data_regs
    import trap_csr_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] VEC_RESET = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter,
    input  logic [XLEN-1:0] cause_in,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] value_in,
    input  logic            wr_en,
    input  csr_sel_e        sel,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] vector_o,
    output logic [XLEN-1:0] retpc_o,
    output logic [XLEN-1:0] cause_o,
    output logic [XLEN-1:0] value_o
);
    typedef struct packed {
        logic [XLEN-1:0] vector;
        logic [XLEN-1:0] retpc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] value;
    } data_t;

    data_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (enter) begin
            rg_d.retpc = pc_in;
            rg_d.cause = cause_in;
            rg_d.value = value_in;
        end else if (wr_en) begin
            case (sel)
                SEL_VECTOR: rg_d.vector = wdata;
                SEL_RETPC:  rg_d.retpc  = wdata;
                SEL_CAUSE:  rg_d.cause  = wdata;
                SEL_VALUE:  rg_d.value  = wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q <= '{vector: VEC_RESET, retpc: '0, cause: '0, value: '0};
        end else begin
            rg_q <= rg_d;
        end
    end

    assign vector_o = rg_q.vector;
    assign retpc_o  = rg_q.retpc;
    assign cause_o  = rg_q.cause;
    assign value_o  = rg_q.value;

    AST_ENTER_LOADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (rg_q.retpc == $past(pc_in) && rg_q.cause == $past(cause_in) &&
                   rg_q.value == $past(value_in)));                         // R3
    AST_ENTER_KEEPS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> $stable(rg_q.vector));                                    // R4
endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
    import trap_csr_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] VEC_RESET = 32'h0000_0100,
    parameter logic [XLEN-1:0] HART_ID   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_enter,
    input  logic              trap_leave,
    input  logic [XLEN-1:0]   trap_cause,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_value,
    input  logic              csr_wr,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_fault,
    output logic [XLEN-1:0]   handler_base,
    output logic [XLEN-1:0]   resume_pc,
    output logic              irq_enable,
    output logic [1:0]        priv_mode
);
    csr_sel_e        sel;
    logic            read_only;
    logic            wr_ok;
    logic            st_wr;
    status_t         st_q;
    logic [XLEN-1:0] cause_q;
    logic [XLEN-1:0] value_q;
    logic [XLEN-1:0] status_word;

    csr_addr_dec i_dec (
        .addr      (csr_addr),
        .sel       (sel),
        .read_only (read_only)
    );

    assign csr_fault = csr_wr && read_only;
    assign wr_ok     = csr_wr && !read_only && !trap_enter && !trap_leave;
    assign st_wr     = wr_ok && (sel == SEL_STATUS);

    trap_status_reg i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter    (trap_enter),
        .leave    (trap_leave),
        .wr_en    (st_wr),
        .wr_ie    (csr_wdata[BIT_IE]),
        .wr_pie   (csr_wdata[BIT_PIE]),
        .wr_ppriv (csr_wdata[BIT_PPRIV+1:BIT_PPRIV]),
        .st_q     (st_q)
    );

    trap_data_regs #(
        .XLEN      (XLEN),
        .VEC_RESET (VEC_RESET)
    ) i_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter    (trap_enter),
        .cause_in (trap_cause),
        .pc_in    (trap_pc),
        .value_in (trap_value),
        .wr_en    (wr_ok),
        .sel      (sel),
        .wdata    (csr_wdata),
        .vector_o (handler_base),
        .retpc_o  (resume_pc),
        .cause_o  (cause_q),
        .value_o  (value_q)
    );

    always_comb begin
        status_word                          = '0;
        status_word[BIT_IE]                  = st_q.ie;
        status_word[BIT_PIE]                 = st_q.pie;
        status_word[BIT_PPRIV+1:BIT_PPRIV]   = st_q.ppriv;
    end

    always_comb begin
        case (sel)
            SEL_STATUS: csr_rdata = status_word;
            SEL_VECTOR: csr_rdata = handler_base;
            SEL_RETPC:  csr_rdata = resume_pc;
            SEL_CAUSE:  csr_rdata = cause_q;
            SEL_VALUE:  csr_rdata = value_q;
            SEL_HARTID: csr_rdata = HART_ID;
            default:    csr_rdata = '0;
        endcase
    end

    assign irq_enable = st_q.ie;
    assign priv_mode  = st_q.priv;

    AST_FAULT_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_fault && !trap_enter && !trap_leave) |=>
            ($stable(handler_base) && $stable(resume_pc) && $stable(cause_q) &&
             $stable(value_q) && $stable(st_q)));                           // R8
    AST_WRITE_IN_LEAVE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && trap_leave && !trap_enter) |=>
            ($stable(handler_base) && $stable(resume_pc) && $stable(cause_q) &&
             $stable(value_q)));                                            // R9
    AST_BOTH_STROBES_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_enter && trap_leave) |=> (!irq_enable && priv_mode == PRIV_MACH)); // R6
    AST_FAULT_ONLY_RO: assert property (@(posedge clk) disable iff (!rst_n)
        csr_fault |-> (csr_wr && csr_addr[CSR_AW-1:CSR_AW-2] == 2'b11));      // R8
endmodule

// File: tb/test_trap_csr_unit.sv
module test_trap_csr_unit;
    localparam int          CLK_PERIOD = 10;
    localparam int          XLEN       = 32;
    localparam logic [31:0] VEC_RST    = 32'h0000_0100;
    localparam logic [31:0] HID        = 32'h0000_0005;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_enter = 1'b0, trap_leave = 1'b0, csr_wr = 1'b0;
    logic [31:0] trap_cause = '0, trap_pc = '0, trap_value = '0, csr_wdata = '0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_rdata, handler_base, resume_pc;
    logic        csr_fault, irq_enable;
    logic [1:0]  priv_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic fault_seen;

    trap_csr_unit #(.XLEN(XLEN), .VEC_RESET(VEC_RST), .HART_ID(HID)) i_trap_csr_unit (
        .clk(clk), .rst_n(rst_n), .trap_enter(trap_enter), .trap_leave(trap_leave),
        .trap_cause(trap_cause), .trap_pc(trap_pc), .trap_value(trap_value),
        .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .csr_fault(csr_fault), .handler_base(handler_base),
        .resume_pc(resume_pc), .irq_enable(irq_enable), .priv_mode(priv_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] st_word(logic ie, logic pie, logic [1:0] pp);
        return (32'(pp) << 11) | (32'(pie) << 7) | (32'(ie) << 3);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // called right after a falling edge, returns right after the next one
    task automatic cyc(logic en, logic lv, logic wr, logic [11:0] a, logic [31:0] wd,
                       logic [31:0] c, logic [31:0] p, logic [31:0] v);
        trap_enter = en; trap_leave = lv; csr_wr = wr; csr_addr = a; csr_wdata = wd;
        trap_cause = c; trap_pc = p; trap_value = v;
        #1 fault_seen = csr_fault;
        @(posedge clk);
        #1;
        trap_enter = 0; trap_leave = 0; csr_wr = 0;
        @(negedge clk);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        cyc(0, 0, 1, a, d, '0, '0, '0);
    endtask

    task automatic rd(string tag, logic [11:0] a, logic [31:0] exp);
        csr_addr = a;
        #1 chk(tag, csr_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 ie", 32'(irq_enable), 0);
        chk("R10 priv", 32'(priv_mode), 3);
        rd("R10 status", 12'h300, 0);
        rd("R10 retpc", 12'h341, 0);
        rd("R10 cause", 12'h342, 0);
        rd("R10 value", 12'h343, 0);
        chk("R4 reset vector", handler_base, VEC_RST);

        // sweep over every (ie, pie, ppriv) status combination
        for (int i = 0; i < 16; i++) begin
            logic       ie  = i[0];
            logic       pie = i[1];
            logic [1:0] pp  = 2'(i >> 2);
            wr(12'h300, st_word(ie, pie, pp) | 32'hFFFF_E777);
            rd("R7 status write", 12'h300, st_word(ie, pie, pp));
            chk("R8 no fault on writable", 32'(fault_seen), 0);
            cyc(0, 1, 0, 12'h000, '0, '0, '0, '0);
            chk("R5 leave ie", 32'(irq_enable), 32'(pie));
            chk("R5 leave priv", 32'(priv_mode), 32'(pp));
            rd("R5 leave status", 12'h300, st_word(pie, 1'b1, 2'b00));
            cyc(1, 0, 0, 12'h000, '0, 32'(i * 7 + 1), 32'h1000 + 32'(i * 4), ~32'(i));
            chk("R1 enter ie", 32'(irq_enable), 0);
            chk("R2 enter priv", 32'(priv_mode), 3);
            rd("R1 R2 enter status", 12'h300, st_word(1'b0, pie, pp));
            chk("R3 retpc", resume_pc, 32'h1000 + 32'(i * 4));
            rd("R3 cause", 12'h342, 32'(i * 7 + 1));
            rd("R3 value", 12'h343, ~32'(i));
        end

        // R6 both strobes together
        wr(12'h300, st_word(1'b1, 1'b1, 2'b10));
        cyc(1, 1, 0, 12'h000, '0, 32'h77, 32'h2220, 32'h33);
        chk("R6 ie", 32'(irq_enable), 0);
        chk("R6 priv", 32'(priv_mode), 3);
        rd("R6 status", 12'h300, st_word(1'b0, 1'b1, 2'b11));
        chk("R6 retpc", resume_pc, 32'h2220);

        // R4 vector write, R7 direct writes
        wr(12'h305, 32'hDEAD_BEE0);
        chk("R4 vector", handler_base, 32'hDEAD_BEE0);
        wr(12'h341, 32'h0000_4444);
        chk("R7 retpc write", resume_pc, 32'h0000_4444);
        wr(12'h342, 32'h8000_0007);
        rd("R7 cause write", 12'h342, 32'h8000_0007);
        wr(12'h343, 32'h1234_5678);
        rd("R7 value write", 12'h343, 32'h1234_5678);

        // R9 write alongside a strobe
        cyc(1, 0, 1, 12'h305, 32'h0BAD_0000, 32'h2, 32'h5000, 32'h0);
        chk("R9 vector during enter", handler_base, 32'hDEAD_BEE0);
        cyc(0, 1, 1, 12'h341, 32'h0BAD_0004, '0, '0, '0);
        chk("R9 retpc during leave", resume_pc, 32'h5000);
        cyc(0, 1, 1, 12'h300, st_word(1'b0, 1'b0, 2'b01), '0, '0, '0);
        rd("R9 status during leave", 12'h300, st_word(1'b1, 1'b1, 2'b00));

        // R8 read-only range, R12 id
        wr(12'hF14, 32'hFFFF_FFFF);
        chk("R8 fault F14", 32'(fault_seen), 1);
        rd("R12 hart id", 12'hF14, HID);
        wr(12'hC00, st_word(1'b0, 1'b0, 2'b01));
        chk("R8 fault C00", 32'(fault_seen), 1);
        rd("R8 status kept", 12'h300, st_word(1'b1, 1'b1, 2'b00));
        chk("R8 ie kept", 32'(irq_enable), 1);

        // R11 unmapped writable address
        wr(12'h7C0, 32'hCAFE_F00D);
        chk("R11 no fault", 32'(fault_seen), 0);
        rd("R11 reads zero", 12'h7C0, 0);
        chk("R11 vector kept", handler_base, 32'hDEAD_BEE0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule